// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block sits between the processor's byte-wide register port and an SMBus bus engine and carries the payload of block transfers. It has two modes. In buffered mode, software loads or unloads a 32-entry byte array through one data port that steps its own index on every access. The engine keeps a separate index for its side of the same array. The block length sits in a count register. In single-byte mode there is no array. Each byte passes through a one-byte holding register. After every data byte the engine is held until software acknowledges by writing 1 to the byte-complete status flag.

The block also keeps the two mode bits that software can read back: CRC enable and buffered-mode enable. It decides when the completion interrupt is raised. When CRC is on, that happens only after the engine reports the end of the checksum phase. Shifting bits on the wire and computing the checksum belong to the engine and are outside this block.

Register map, addressed by `reg_addr`:

- 0: status.
  - bit0 is byte-complete.
  - bit1 is interrupt.
  - bit2 is failed.
  - Writing 1 to a bit clears it.
- 1: control. 8 bits, read/write; bit0 marks the final read byte.
- 2: count.
- 3: data port.
- 4: mode.
  - bit0 is CRC enable.
  - bit1 is buffered mode.

Top module: `smb_blkbuf`

## Requirements
- R1: The mode register (address 4) keeps bit0 (CRC enable) and bit1 (buffered mode) as read/write bits. Its other bits read as 0. `eng_crc_en` follows bit0.
- R2: Any read of the control register (address 1) sets the software-side array index back to entry 0.
- R3: In buffered mode, each write to the data port (address 3) stores the byte at the current index and advances the index. Each read returns the entry at the index and advances it, so bytes come back in the order they were written.
- R4: Software data-port accesses at index 32 or above change nothing, neither the index nor any entry. Reads there return 0x00.
- R5: Software can write and read the count register (address 2), and `eng_count` presents its value. The first byte the engine receives after `eng_start` loads the count in either mode.
- R6: In single-byte mode, each data byte the engine sends or receives sets status bit0 and raises `eng_hold`. Writing 1 to status bit0 clears both. Writing 0 there has no effect.
- R7: In single-byte mode, a software data-port write appears on `eng_tx_byte`. A received data byte (any byte after the count) can be read at the data port.
- R8: In single-byte mode, `eng_last` equals control bit0. In buffered mode `eng_last` is 0.
- R9: With CRC disabled, `eng_data_done` sets status bit1 and `irq`. With CRC enabled, `eng_data_done` has no effect and only `eng_pec_done` sets them.
- R10: In buffered mode, a received count of 0 or above 32 sets status bit2 (failed) and raises `eng_hold`. Counts from 1 to 32 do not.
- R11: In buffered mode, `eng_start` resets the engine-side index. Received data bytes fill the array from entry 0 in order. `eng_tx_byte` shows the entry at the engine index, which `eng_tx_take` advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| eng_start | input | 1 | Engine begins a block transaction |
| eng_rx_vld | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_tx_take | input | 1 | Engine consumed the presented transmit byte |
| eng_tx_byte | output | 8 | Next byte for the engine to send |
| eng_count | output | 8 | Block length for the engine |
| eng_hold | output | 1 | Engine must stall |
| eng_last | output | 1 | Final read byte is to be NACKed |
| eng_crc_en | output | 1 | Engine appends or checks the CRC byte |
| eng_data_done | input | 1 | Last data byte finished |
| eng_pec_done | input | 1 | CRC phase finished |
| irq | output | 1 | Completion interrupt (status bit1) |

## Verification
A wrong software index shows up on the first data-port read after a control read, as a byte out of order or a nonzero value past entry 31. A wrong engine index shows on `eng_tx_byte` in the cycle after `eng_start` or `eng_tx_take`. A broken byte-complete or failed flag is visible on `eng_hold` one cycle after the engine event or the software clear. A mis-gated interrupt is visible on `irq` one cycle after the engine's done pulse.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] A_STAT = 3'd0;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] A_CNT  = 3'd2;
    localparam logic [REG_AW-1:0] A_DATA = 3'd3;
    localparam logic [REG_AW-1:0] A_MODE = 3'd4;

    localparam int ST_DONE = 0;
    localparam int ST_INTR = 1;
    localparam int ST_FAIL = 2;
    localparam int MD_CRC  = 0;
    localparam int MD_BUF  = 1;
endpackage

// File: rtl/smb_blkbuf_store.sv
module smb_blkbuf_store #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         idx_clr,
    input  logic         cpu_wr,
    input  logic         cpu_rd,
    input  logic [W-1:0] cpu_wdata,
    output logic [W-1:0] cpu_rdata,
    input  logic         eng_clr,
    input  logic         eng_wr,
    input  logic         eng_adv,
    input  logic [W-1:0] eng_wdata,
    output logic [W-1:0] eng_rdata
);
    localparam int IW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);
    localparam logic [IW-1:0] LIM = IW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [IW-1:0]           cpu_idx;
        logic [IW-1:0]           eng_idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idx_clr) begin
            st_d.cpu_idx = '0;
        end else if ((cpu_wr || cpu_rd) && st_q.cpu_idx < LIM) begin
            if (cpu_wr) st_d.mem[st_q.cpu_idx[AW-1:0]] = cpu_wdata;
            st_d.cpu_idx = st_q.cpu_idx + IW'(1);
        end
        if (eng_clr) begin
            st_d.eng_idx = '0;
        end else if ((eng_wr || eng_adv) && st_q.eng_idx < LIM) begin
            if (eng_wr) st_d.mem[st_q.eng_idx[AW-1:0]] = eng_wdata;
            st_d.eng_idx = st_q.eng_idx + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_rdata = (st_q.cpu_idx < LIM) ? st_q.mem[st_q.cpu_idx[AW-1:0]] : '0;
    assign eng_rdata = (st_q.eng_idx < LIM) ? st_q.mem[st_q.eng_idx[AW-1:0]] : '0;

    // R2: control read returns the software index to entry 0
    p_idx_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clr |=> st_q.cpu_idx == '0);

    // R3: an in-range access steps the index by one
    p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_wr || cpu_rd) && !idx_clr && st_q.cpu_idx < LIM)
        |=> st_q.cpu_idx == $past(st_q.cpu_idx) + IW'(1));

    // R4: writes past the end leave storage and index untouched
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !idx_clr && !eng_wr && st_q.cpu_idx >= LIM)
        |=> ($stable(st_q.mem) && $stable(st_q.cpu_idx)));
endmodule

// File: rtl/smb_blkbuf_flags.sv
module smb_blkbuf_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_wr,
    input  logic [2:0] st_clr,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       set_done,
    input  logic       set_fail,
    input  logic       data_done,
    input  logic       pec_done,
    output logic [2:0] status,
    output logic [1:0] mode
);
    import smb_blkbuf_pkg::*;

    typedef struct packed {
        logic [2:0] sts;
        logic [1:0] mode;
    } fl_t;

    fl_t fl_d, fl_q;
    logic set_intr;

    always_comb begin
        fl_d = fl_q;
        set_intr = fl_q.mode[MD_CRC] ? pec_done : data_done;
        if (st_wr)   fl_d.sts  = fl_q.sts & ~st_clr;
        if (mode_wr) fl_d.mode = mode_wdata;
        if (set_done) fl_d.sts[ST_DONE] = 1'b1;
        if (set_intr) fl_d.sts[ST_INTR] = 1'b1;
        if (set_fail) fl_d.sts[ST_FAIL] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign status = fl_q.sts;
    assign mode   = fl_q.mode;

    // R1: mode bits read back what was written
    p_mode_rb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode == $past(mode_wdata));

    // R6: a 1 written to byte-complete clears it unless a new byte lands
    p_done_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_clr[ST_DONE] && !set_done) |=> !status[ST_DONE]);

    // R9: with CRC on, data completion alone never raises the interrupt
    p_intr_pec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[MD_CRC] && !mode_wr && !pec_done && !status[ST_INTR]) |=> !status[ST_INTR]);
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       eng_start,
    input  logic       eng_rx_vld,
    input  logic [7:0] eng_rx_byte,
    input  logic       eng_tx_take,
    output logic [7:0] eng_tx_byte,
    output logic [7:0] eng_count,
    output logic       eng_hold,
    output logic       eng_last,
    output logic       eng_crc_en,
    input  logic       eng_data_done,
    input  logic       eng_pec_done,
    output logic       irq
);
    import smb_blkbuf_pkg::*;

    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] ctrl;
        logic [W-1:0] count;
        logic [W-1:0] hold_byte;
        logic         first;
    } top_t;

    top_t t_d, t_q;

    logic [2:0]   status;
    logic [1:0]   mode;
    logic         buf_en;
    logic         rx_count, rx_data, bad_count;
    logic         cpu_data_wr, cpu_data_rd;
    logic [W-1:0] store_cpu_rdata, store_eng_rdata;

    assign buf_en      = mode[MD_BUF];
    assign rx_count    = eng_rx_vld && t_q.first;
    assign rx_data     = eng_rx_vld && !t_q.first;
    assign bad_count   = (eng_rx_byte == '0) || (int'(eng_rx_byte) > DEPTH);
    assign cpu_data_wr = reg_wr && reg_addr == A_DATA;
    assign cpu_data_rd = reg_rd && reg_addr == A_DATA;

    always_comb begin
        t_d = t_q;
        if (reg_wr && reg_addr == A_CTRL) t_d.ctrl  = reg_wdata;
        if (reg_wr && reg_addr == A_CNT)  t_d.count = reg_wdata;
        if (rx_count)                     t_d.count = eng_rx_byte;
        if (!buf_en && cpu_data_wr)       t_d.hold_byte = reg_wdata;
        if (!buf_en && rx_data)           t_d.hold_byte = eng_rx_byte;
        if (eng_start)                    t_d.first = 1'b1;
        else if (eng_rx_vld)              t_d.first = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    smb_blkbuf_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_clr   (reg_rd && reg_addr == A_CTRL),
        .cpu_wr    (buf_en && cpu_data_wr),
        .cpu_rd    (buf_en && cpu_data_rd),
        .cpu_wdata (reg_wdata),
        .cpu_rdata (store_cpu_rdata),
        .eng_clr   (eng_start),
        .eng_wr    (buf_en && rx_data),
        .eng_adv   (buf_en && eng_tx_take),
        .eng_wdata (eng_rx_byte),
        .eng_rdata (store_eng_rdata)
    );

    smb_blkbuf_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_wr      (reg_wr && reg_addr == A_STAT),
        .st_clr     (reg_wdata[2:0]),
        .mode_wr    (reg_wr && reg_addr == A_MODE),
        .mode_wdata (reg_wdata[1:0]),
        .set_done   (!buf_en && (rx_data || eng_tx_take)),
        .set_fail   (buf_en && rx_count && bad_count),
        .data_done  (eng_data_done),
        .pec_done   (eng_pec_done),
        .status     (status),
        .mode       (mode)
    );

    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = {5'b0, status};
            A_CTRL:  reg_rdata = t_q.ctrl;
            A_CNT:   reg_rdata = t_q.count;
            A_DATA:  reg_rdata = buf_en ? store_cpu_rdata : t_q.hold_byte;
            A_MODE:  reg_rdata = {6'b0, mode};
            default: reg_rdata = '0;
        endcase
    end

    assign eng_tx_byte = buf_en ? store_eng_rdata : t_q.hold_byte;
    assign eng_count   = t_q.count;
    assign eng_hold    = status[ST_DONE] || status[ST_FAIL];
    assign eng_last    = !buf_en && t_q.ctrl[0];
    assign eng_crc_en  = mode[MD_CRC];
    assign irq         = status[ST_INTR];

    // R10: an out-of-range count in buffered mode stalls the engine
    p_bad_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && rx_count && bad_count) |=> eng_hold);

    // R5: the first received byte becomes the count
    p_count_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count |=> eng_count == $past(eng_rx_byte));
endmodule

// File: tb/smb_blkbuf_tb.sv
module smb_blkbuf_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_start = 1'b0, eng_rx_vld = 1'b0, eng_tx_take = 1'b0;
    logic [7:0] eng_rx_byte = '0;
    logic [7:0] eng_tx_byte, eng_count;
    logic       eng_hold, eng_last, eng_crc_en, irq;
    logic       eng_data_done = 1'b0, eng_pec_done = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    smb_blkbuf dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_rx_vld(eng_rx_vld), .eng_rx_byte(eng_rx_byte),
        .eng_tx_take(eng_tx_take), .eng_tx_byte(eng_tx_byte), .eng_count(eng_count),
        .eng_hold(eng_hold), .eng_last(eng_last), .eng_crc_en(eng_crc_en),
        .eng_data_done(eng_data_done), .eng_pec_done(eng_pec_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: compares each register read against the scoreboard queue
    always @(posedge clk) begin
        if (reg_rd) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard-empty", 8'h00, 8'hff);
            end else begin
                chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng_begin();
        @(negedge clk); eng_start = 1'b1;
        @(negedge clk); eng_start = 1'b0;
    endtask

    task automatic eng_rx(input logic [7:0] b);
        @(negedge clk); eng_rx_vld = 1'b1; eng_rx_byte = b;
        @(negedge clk); eng_rx_vld = 1'b0;
    endtask

    task automatic eng_take();
        @(negedge clk); eng_tx_take = 1'b1;
        @(negedge clk); eng_tx_take = 1'b0;
    endtask

    task automatic pulse_data_done();
        @(negedge clk); eng_data_done = 1'b1;
        @(negedge clk); eng_data_done = 1'b0;
    endtask

    task automatic pulse_pec_done();
        @(negedge clk); eng_pec_done = 1'b1;
        @(negedge clk); eng_pec_done = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset crc", {7'b0, eng_crc_en}, 8'h00);
        chk("R6 reset hold", {7'b0, eng_hold}, 8'h00);
        chk("R9 reset irq", {7'b0, irq}, 8'h00);
        rd(3'd0, 8'h00, "R6 reset status");
        rd(3'd4, 8'h00, "R1 reset mode");

        // R1 mode bits
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'h03, "R1 mode readback ff");
        chk("R1 crc out", {7'b0, eng_crc_en}, 8'h01);
        wr(3'd4, 8'h02);
        rd(3'd4, 8'h02, "R1 mode readback 02");

        // R3 buffered fill and drain, R2 index reset
        rd(3'd1, 8'h00, "R2 ctrl read");
        wr(3'd3, 8'h11); wr(3'd3, 8'h22); wr(3'd3, 8'h33);
        rd(3'd1, 8'h00, "R2 ctrl read");
        rd(3'd3, 8'h11, "R3 entry0");
        rd(3'd3, 8'h22, "R3 entry1");
        rd(3'd1, 8'h00, "R2 ctrl read rewinds");
        rd(3'd3, 8'h11, "R2 entry0 again");

        // R11 engine transmit order
        eng_begin();
        chk("R11 tx entry0", eng_tx_byte, 8'h11);
        eng_take();
        chk("R11 tx entry1", eng_tx_byte, 8'h22);
        chk("R11 no byte-done in buffered mode", {7'b0, eng_hold}, 8'h00);
        eng_take();
        chk("R11 tx entry2", eng_tx_byte, 8'h33);

        // R8 in buffered mode
        wr(3'd1, 8'h01);
        chk("R8 last gated in buffered mode", {7'b0, eng_last}, 8'h00);

        // R4 saturation
        rd(3'd1, 8'h01, "R2 ctrl read");
        for (int i = 0; i < 32; i++) wr(3'd3, 8'(i * 3 + 1));
        wr(3'd3, 8'hEE);
        rd(3'd1, 8'h01, "R2 ctrl read");
        for (int i = 0; i < 32; i++) rd(3'd3, 8'(i * 3 + 1), "R4 full array");
        rd(3'd3, 8'h00, "R4 read past end");
        rd(3'd3, 8'h00, "R4 read past end again");

        // R5 count register
        wr(3'd2, 8'h05);
        chk("R5 eng_count", eng_count, 8'h05);
        rd(3'd2, 8'h05, "R5 count readback");

        // R11 / R5 buffered receive
        eng_begin();
        eng_rx(8'h03); eng_rx(8'hAA); eng_rx(8'hBB); eng_rx(8'hCC);
        rd(3'd2, 8'h03, "R5 count loaded");
        rd(3'd0, 8'h00, "R10 valid count no fail");
        rd(3'd1, 8'h01, "R2 ctrl read");
        rd(3'd3, 8'hAA, "R11 rx entry0");
        rd(3'd3, 8'hBB, "R11 rx entry1");
        rd(3'd3, 8'hCC, "R11 rx entry2");

        // R10 bad counts
        eng_begin(); eng_rx(8'h00);
        rd(3'd0, 8'h04, "R10 zero count fails");
        chk("R10 hold on zero", {7'b0, eng_hold}, 8'h01);
        wr(3'd0, 8'h04);
        rd(3'd0, 8'h00, "R10 fail cleared");
        eng_begin(); eng_rx(8'h21);
        rd(3'd0, 8'h04, "R10 count 33 fails");
        wr(3'd0, 8'h04);
        eng_begin(); eng_rx(8'h20);
        rd(3'd0, 8'h00, "R10 count 32 ok");
        chk("R10 no hold at 32", {7'b0, eng_hold}, 8'h00);
        chk("R5 count 32", eng_count, 8'h20);

        // single-byte mode
        wr(3'd4, 8'h00);
        chk("R8 last follows ctrl", {7'b0, eng_last}, 8'h01);
        wr(3'd1, 8'h00);
        chk("R8 last cleared", {7'b0, eng_last}, 8'h00);
        wr(3'd3, 8'h5A);
        chk("R7 tx holding byte", eng_tx_byte, 8'h5A);
        rd(3'd0, 8'h00, "R6 no done before byte");
        eng_take();
        rd(3'd0, 8'h01, "R6 done after tx");
        chk("R6 hold raised", {7'b0, eng_hold}, 8'h01);
        wr(3'd0, 8'h00);
        rd(3'd0, 8'h01, "R6 write 0 ignored");
        chk("R6 still held", {7'b0, eng_hold}, 8'h01);
        wr(3'd0, 8'h01);
        rd(3'd0, 8'h00, "R6 cleared by 1");
        chk("R6 released", {7'b0, eng_hold}, 8'h00);
        eng_begin(); eng_rx(8'h02);
        rd(3'd0, 8'h00, "R6 count byte sets no done");
        chk("R5 count in byte mode", eng_count, 8'h02);
        eng_rx(8'h77);
        rd(3'd0, 8'h01, "R6 done after rx");
        rd(3'd3, 8'h77, "R7 rx holding byte");
        wr(3'd0, 8'h01);

        // R9 interrupt gating
        pulse_data_done();
        rd(3'd0, 8'h02, "R9 intr without crc");
        chk("R9 irq", {7'b0, irq}, 8'h01);
        wr(3'd0, 8'h02);
        chk("R9 irq cleared", {7'b0, irq}, 8'h00);
        wr(3'd4, 8'h01);
        pulse_data_done();
        chk("R9 data done ignored with crc", {7'b0, irq}, 8'h00);
        rd(3'd0, 8'h00, "R9 status after data done");
        pulse_pec_done();
        chk("R9 irq after pec", {7'b0, irq}, 8'h01);
        rd(3'd0, 8'h02, "R9 status after pec");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("scoreboard-drain", 8'(exp_q.size()), 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule